// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block reads a 12-key switch matrix arranged as four rows and three columns. It pulls one row low at a time and leaves the other three high. The column lines idle high through external pull-ups, so any column that reads low marks a closed switch in the driven row. The column inputs pass through a two-flop synchronizer first. Row stepping and column sampling follow a prescaled scan tick rather than every clock, so each row has a full tick to settle before its columns are read.

When a closure is seen, the scanner stops on that row and records the column. It then waits a debounce interval of `DEBOUNCE_TICKS` scan ticks. The key is reported only if the same switch is still closed when that interval ends. A report is a one-clock `key_valid` pulse together with a key number from 1 to 12. The key number is the 1-based column plus three times the 1-based row, minus three. The key number stays on `key_code` until the next report.

The `repeat_en` input selects between two behaviours. In one mode the held key is reported again every `REPEAT_TICKS` ticks. In the other mode the key is reported once, and the scanner waits for the key to be released before it accepts another press. A release counts only after the row's columns have read high for a full debounce interval. With a 1 ms tick, `DEBOUNCE_TICKS` covers intervals from about 10 ms up to several hundred ms.

Top module: `kpd_scanner`

## Requirements
- R1: Exactly one bit of `row_n` is low at every clock after reset. Bit i drives row i+1. Reset leaves row 1 driven (`row_n` = 4'b1110), `key_valid` at 0 and `key_code` at 0.
- R2: `row_n` changes only on a scan tick, at most once every `TICK_DIV` clocks. Columns are sampled through a two-flop synchronizer one tick after their row was driven.
- R3: While no column reads 0 during any row, no `key_valid` pulse occurs.
- R4: Bit j of `col_n` is column j+1. The reported code is column + 3*row - 3, which gives 1 to 12. When several columns of a row are low, the lowest-numbered column wins.
- R5: A key is reported only when its switch is still closed `DEBOUNCE_TICKS` ticks after detection. The first report therefore comes no sooner than `DEBOUNCE_TICKS*TICK_DIV` clocks after the press, and a closure shorter than that gives no report.
- R6: With `repeat_en`=0, a held key is reported exactly once. A new press after a confirmed release is reported again.
- R7: With `repeat_en`=1, a held key is reported again every `REPEAT_TICKS*TICK_DIV` clocks after its first report.
- R8: `key_valid` is high for one clock at a time. `key_code` changes only in a cycle where `key_valid` is high.
- R9: A release lasting fewer than `DEBOUNCE_TICKS` ticks is not a release. Closing the key again after such a gap gives no new report in once mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| repeat_en | input | 1 | 1 = repeat while held, 0 = one report per press |
| col_n | input | COLS (3) | Column sense lines, active low, idle high |
| row_n | output | ROWS (4) | Row drive lines, selected row low |
| key_valid | output | 1 | One-clock report strobe |
| key_code | output | CODE_W (4) | Key number 1..12, held between reports |

## Verification
The bench builds the scanner with `TICK_DIV`=4, `DEBOUNCE_TICKS`=6 and `REPEAT_TICKS`=10. With these values a full pass over the rows takes 16 clocks, a debounce interval takes 24 clocks and the repeat period takes 40 clocks. Every key, bounce, short release gap and repeat sequence therefore completes in a few hundred cycles. A behavioural switch matrix in the bench pulls a column low only while the pressed key's row is driven. This makes the row-sampling order, the lowest-column rule for two keys in one row, and the exact repeat spacing directly observable.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  typedef enum logic [1:0] {
    ST_SCAN   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HELD   = 2'd2
  } kpd_state_e;
endpackage

// File: rtl/kpd_tick_gen.sv
module kpd_tick_gen #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/kpd_col_sync.sv
module kpd_col_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta    <= 1'b1;
        dout[i] <= 1'b1;
      end else begin
        meta    <= din[i];
        dout[i] <= meta;
      end
    end
  end
endmodule

// File: rtl/kpd_col_pick.sv
module kpd_col_pick #(
  parameter int COLS = 3,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic [COLS-1:0] col_n,
  output logic            any_low,
  output logic [CW-1:0]   idx
);
  always_comb begin
    any_low = 1'b0;
    idx     = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (!col_n[i]) begin
        any_low = 1'b1;
        idx     = CW'(i);
      end
    end
  end
endmodule

// File: rtl/kpd_ctrl.sv
module kpd_ctrl
  import kpd_pkg::*;
#(
  parameter int ROWS           = 4,
  parameter int COLS           = 3,
  parameter int DEBOUNCE_TICKS = 20,
  parameter int REPEAT_TICKS   = 100,
  localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW     = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CODE_W = $clog2(ROWS * COLS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              repeat_en,
  input  logic [COLS-1:0]   col_sync,
  input  logic              col_any,
  input  logic [CW-1:0]     col_idx,
  output logic [ROWS-1:0]   row_n,
  output logic              key_valid,
  output logic [CODE_W-1:0] key_code
);
  localparam int DW = $clog2(DEBOUNCE_TICKS + 1);
  localparam int PW = $clog2(REPEAT_TICKS + 1);

  kpd_state_e        state;
  logic [RW-1:0]     row_q;
  logic [CW-1:0]     col_q;
  logic [DW-1:0]     deb_cnt;
  logic [PW-1:0]     rep_cnt;
  logic [RW-1:0]     row_nxt;
  logic [CODE_W-1:0] key_num;
  logic              held_low;

  always_comb begin
    row_nxt  = (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
    key_num  = CODE_W'(col_q) + CODE_W'(COLS) * CODE_W'(row_q) + CODE_W'(1);
    held_low = ~col_sync[col_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SCAN;
      row_q     <= '0;
      row_n     <= ~ROWS'(1);
      col_q     <= '0;
      deb_cnt   <= '0;
      rep_cnt   <= '0;
      key_valid <= 1'b0;
      key_code  <= '0;
    end else begin
      key_valid <= 1'b0;
      if (tick) begin
        case (state)
          ST_SCAN: begin
            if (col_any) begin
              col_q   <= col_idx;
              deb_cnt <= '0;
              state   <= ST_SETTLE;
            end else begin
              row_q <= row_nxt;
              row_n <= ~(ROWS'(1) << row_nxt);
            end
          end
          ST_SETTLE: begin
            if (deb_cnt == DW'(DEBOUNCE_TICKS - 1)) begin
              deb_cnt <= '0;
              if (held_low) begin
                key_valid <= 1'b1;
                key_code  <= key_num;
                rep_cnt   <= '0;
                state     <= ST_HELD;
              end else begin
                row_q <= row_nxt;
                row_n <= ~(ROWS'(1) << row_nxt);
                state <= ST_SCAN;
              end
            end else begin
              deb_cnt <= deb_cnt + 1'b1;
            end
          end
          ST_HELD: begin
            if (held_low) begin
              deb_cnt <= '0;
              if (!repeat_en) begin
                rep_cnt <= '0;
              end else if (rep_cnt == PW'(REPEAT_TICKS - 1)) begin
                rep_cnt   <= '0;
                key_valid <= 1'b1;
                key_code  <= key_num;
              end else begin
                rep_cnt <= rep_cnt + 1'b1;
              end
            end else begin
              rep_cnt <= '0;
              if (deb_cnt == DW'(DEBOUNCE_TICKS - 1)) begin
                deb_cnt <= '0;
                row_q   <= row_nxt;
                row_n   <= ~(ROWS'(1) << row_nxt);
                state   <= ST_SCAN;
              end else begin
                deb_cnt <= deb_cnt + 1'b1;
              end
            end
          end
          default: state <= ST_SCAN;
        endcase
      end
    end
  end
endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner #(
  parameter int ROWS           = 4,
  parameter int COLS           = 3,
  parameter int TICK_DIV       = 50000,
  parameter int DEBOUNCE_TICKS = 20,
  parameter int REPEAT_TICKS   = 100,
  localparam int CW     = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CODE_W = $clog2(ROWS * COLS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              repeat_en,
  input  logic [COLS-1:0]   col_n,
  output logic [ROWS-1:0]   row_n,
  output logic              key_valid,
  output logic [CODE_W-1:0] key_code
);
  logic            scan_tick;
  logic [COLS-1:0] col_sync;
  logic            col_any;
  logic [CW-1:0]   col_idx;

  kpd_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(scan_tick)
  );

  kpd_col_sync #(.W(COLS)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (col_n),
    .dout(col_sync)
  );

  kpd_col_pick #(.COLS(COLS)) u_pick (
    .col_n  (col_sync),
    .any_low(col_any),
    .idx    (col_idx)
  );

  kpd_ctrl #(
    .ROWS          (ROWS),
    .COLS          (COLS),
    .DEBOUNCE_TICKS(DEBOUNCE_TICKS),
    .REPEAT_TICKS  (REPEAT_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (scan_tick),
    .repeat_en(repeat_en),
    .col_sync (col_sync),
    .col_any  (col_any),
    .col_idx  (col_idx),
    .row_n    (row_n),
    .key_valid(key_valid),
    .key_code (key_code)
  );
endmodule

// File: rtl/kpd_scanner_chk.sv
module kpd_scanner_chk #(
  parameter int ROWS   = 4,
  parameter int COLS   = 3,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_tick,
  input logic [ROWS-1:0]   row_n,
  input logic              key_valid,
  input logic [CODE_W-1:0] key_code
);
  // R1
  a_r1_single_row_low: assert property (@(posedge clk) disable iff (rst)
    $countones(~row_n) == 1);

  // R2
  a_r2_row_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !scan_tick |=> $stable(row_n));

  // R4
  a_r4_code_range: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> (key_code >= CODE_W'(1) && key_code <= CODE_W'(ROWS * COLS)));

  // R8
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  // R8
  a_r8_code_held: assert property (@(posedge clk) disable iff (rst)
    !key_valid |-> $stable(key_code));
endmodule

bind kpd_scanner kpd_scanner_chk #(
  .ROWS  (ROWS),
  .COLS  (COLS),
  .CODE_W(CODE_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scan_tick(scan_tick),
  .row_n    (row_n),
  .key_valid(key_valid),
  .key_code (key_code)
);

// File: tb/test_kpd_scanner.sv
`timescale 1ns/1ps
module test_kpd_scanner;
  localparam int TDIV = 4;
  localparam int DEB  = 6;
  localparam int REP  = 10;

  // {row index, col index, expected code}, code = col + 3*row - 3 (1-based)
  localparam logic [7:0] KEYS [12] = '{
    {2'd0, 2'd0, 4'd1},  {2'd3, 2'd2, 4'd12}, {2'd1, 2'd1, 4'd5},
    {2'd2, 2'd0, 4'd7},  {2'd0, 2'd2, 4'd3},  {2'd3, 2'd0, 4'd10},
    {2'd1, 2'd0, 4'd4},  {2'd2, 2'd2, 4'd9},  {2'd0, 2'd1, 4'd2},
    {2'd3, 2'd1, 4'd11}, {2'd1, 2'd2, 4'd6},  {2'd2, 2'd1, 4'd8}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       repeat_en = 1'b0;
  logic [2:0] col_n;
  logic [3:0] row_n;
  logic       key_valid;
  logic [3:0] key_code;
  logic [11:0] mask = '0;

  int tests = 0, fails = 0;
  int cyc = 0, pulses = 0, last_pc = 0, prev_pc = 0;
  int bad_width = 0, bad_hold = 0, bad_row = 0, bad_step = 0, row_chg = 0;
  logic [3:0] last_code = '0, code_prev = '0, row_prev = 4'b1110;
  logic       valid_prev = 1'b0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    col_n = 3'b111;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 3; c++)
        if (mask[r*3+c] && !row_n[r]) col_n[c] = 1'b0;
  end

  kpd_scanner #(.TICK_DIV(TDIV), .DEBOUNCE_TICKS(DEB), .REPEAT_TICKS(REP)) i_kpd_scanner (
    .clk(clk), .rst(rst), .repeat_en(repeat_en), .col_n(col_n),
    .row_n(row_n), .key_valid(key_valid), .key_code(key_code)
  );

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (key_valid) begin
        pulses++;
        last_code = key_code;
        prev_pc = last_pc;
        last_pc = cyc;
      end
      if (key_valid && valid_prev) bad_width++;
      if (!key_valid && key_code != code_prev) bad_hold++;
      if ($countones(~row_n) != 1) bad_row++;
      if (row_n != row_prev) begin
        if (cyc - row_chg < TDIV) bad_step++;
        row_chg = cyc;
      end
    end
    valid_prev = key_valid;
    code_prev  = key_code;
    row_prev   = row_n;
  end

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(int p0, int limit);
    for (int i = 0; i < limit && pulses == p0; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int p0, t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(row_n == 4'b1110, "R1 reset row", row_n, 14);
    check(key_valid == 1'b0, "R1 reset valid", key_valid, 0);
    check(key_code == 4'd0, "R1 reset code", key_code, 0);

    // R3 idle
    repeat (300) @(negedge clk);
    check(pulses == 0, "R3 idle no report", pulses, 0);

    // R4/R5/R6 every key, once mode
    for (int k = 0; k < 12; k++) begin
      p0 = pulses;
      t0 = cyc;
      mask = 12'(1) << (KEYS[k][7:6] * 3 + KEYS[k][5:4]);
      wait_pulse(p0, 400);
      check(pulses == p0 + 1 && last_code == KEYS[k][3:0], "R4 key code",
            last_code, KEYS[k][3:0]);
      check(last_pc - t0 >= DEB * TDIV, "R5 debounce latency", last_pc - t0, DEB * TDIV);
      repeat (200) @(negedge clk);
      check(pulses == p0 + 1, "R6 single report while held", pulses - p0, 1);
      mask = '0;
      repeat (150) @(negedge clk);
    end

    // R5 bounce shorter than debounce
    p0 = pulses;
    mask = 12'b000_000_010_000;
    repeat (8) @(negedge clk);
    mask = '0;
    repeat (300) @(negedge clk);
    check(pulses == p0, "R5 short closure ignored", pulses - p0, 0);

    // R4 two keys in one row -> lowest column (row2 col2 = 5)
    p0 = pulses;
    mask = 12'b000_000_110_000;
    wait_pulse(p0, 400);
    check(pulses == p0 + 1 && last_code == 4'd5, "R4 lowest column", last_code, 5);
    mask = '0;
    repeat (150) @(negedge clk);

    // R9 short release gap, then R6 new press
    p0 = pulses;
    mask = 12'b000_000_000_001;
    wait_pulse(p0, 400);
    repeat (20) @(negedge clk);
    mask = '0;
    repeat (8) @(negedge clk);
    mask = 12'b000_000_000_001;
    repeat (200) @(negedge clk);
    check(pulses == p0 + 1, "R9 short gap not release", pulses - p0, 1);
    mask = '0;
    repeat (150) @(negedge clk);
    mask = 12'b000_000_000_001;
    wait_pulse(p0 + 1, 400);
    check(pulses == p0 + 2 && last_code == 4'd1, "R6 new press after release",
          pulses - p0, 2);
    mask = '0;
    repeat (150) @(negedge clk);

    // R7 repeat mode, row3 col2 = 8
    repeat_en = 1'b1;
    p0 = pulses;
    mask = 12'b000_010_000_000;
    wait_pulse(p0, 400);
    wait_pulse(p0 + 1, 200);
    check(last_pc - prev_pc == REP * TDIV, "R7 repeat spacing", last_pc - prev_pc, REP * TDIV);
    wait_pulse(p0 + 2, 200);
    check(last_pc - prev_pc == REP * TDIV, "R7 repeat spacing 2", last_pc - prev_pc, REP * TDIV);
    check(pulses == p0 + 3 && last_code == 4'd8, "R7 repeat code", last_code, 8);
    mask = '0;
    repeat (150) @(negedge clk);
    repeat_en = 1'b0;

    // monitors
    check(bad_width == 0, "R8 pulse width", bad_width, 0);
    check(bad_hold == 0, "R8 code hold", bad_hold, 0);
    check(bad_row == 0, "R1 one row low", bad_row, 0);
    check(bad_step == 0, "R2 row step spacing", bad_step, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule